// File: doc/BRIEF.md
# Multi-buffer circular memory engine

The engine keeps several logical ring buffers inside one shared local data RAM. Each buffer has a base word address and a length that can be rewritten at run time. Writing a buffer's configuration empties it. Words enter a buffer from an external ingress port. They can also enter through a loop path, in which a read engine copies words from its own buffer into another buffer held in the same RAM.

Each buffer has one read engine. A read engine runs a short microprogram held in a small per-engine register file. The microprogram reads words from the engine's own buffer and sends them to one of four destinations: the network egress port, DSP input 0, DSP input 1, or the loop path. Engines can hand each other one-bit synchronisation tokens. Every cycle, a fixed-priority arbiter gives the single RAM read port to one engine, and the read word is steered to the registered output of the chosen destination.

The RAM has one read port and one write port. Its depth is set by a parameter: with `AW` = 13 it holds 8192 words of 32 bits. The default is smaller to keep elaboration light.

Top module: `rbe_top`

## Requirements
- R1: After reset, `net_valid`, `dsp0_valid` and `dsp1_valid` are low and every bit of `rp_idle` is high.
- R2: A cycle with `cfg_we` high loads `cfg_base` and `cfg_size` into buffer `cfg_sel` and empties that buffer. A buffer of size 0 never accepts a word, so `in_ready` is low while `in_sel` selects it.
- R3: A buffer returns its words in the order they were written. Its storage runs from base to base+size-1 and wraps back to base, and word order is kept across the wrap.
- R4: A buffer that holds `size` words refuses further writes (`in_ready` low), and its fill count never exceeds its size.
- R5: A read engine whose buffer is empty stalls and produces no output. It resumes when a word arrives.
- R6: Instruction word layout: bits [15:14] hold the opcode (0 HALT, 1 READ, 2 WAIT, 3 SIGNAL). For READ, bits [13:12] hold the destination (0 network, 1 DSP0, 2 DSP1, 3 loop), bits [11:10] hold the loop buffer, and bits [9:0] hold the word count N. READ sends exactly N words to its destination and to no other port.
- R7: READ with destination 3 writes each word into the buffer named in bits [11:10], where that buffer's engine can read it.
- R8: SIGNAL (peer in bits [1:0]) raises a token from the issuing engine to the peer. WAIT (peer in bits [1:0]) stalls until a token from that peer is pending, then consumes it.
- R9: When several engines can read in the same cycle, the lowest-numbered engine is granted first.
- R10: An output whose valid is high while its ready is low keeps valid high and its data unchanged in the next cycle.
- R11: HALT ends the program and raises the engine's `rp_idle` bit. READ with N = 0 completes at once and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configure buffer `cfg_sel` |
| cfg_sel | input | BW | Buffer being configured |
| cfg_base | input | AW | Base word address |
| cfg_size | input | AW+1 | Buffer length in words |
| prog_we | input | 1 | Write one program word |
| prog_sel | input | BW | Engine whose program is written |
| prog_idx | input | PW | Program slot |
| prog_word | input | 16 | Instruction word |
| rp_start | input | NB | Start pulse per engine (begins at slot 0) |
| rp_idle | output | NB | Engine is not running |
| in_valid | input | 1 | Ingress word valid |
| in_sel | input | BW | Ingress destination buffer |
| in_data | input | DW | Ingress word |
| in_ready | output | 1 | Ingress word accepted |
| net_valid | output | 1 | Network egress valid |
| net_data | output | DW | Network egress word |
| net_ready | input | 1 | Network egress ready |
| dsp0_valid | output | 1 | DSP0 input valid |
| dsp0_data | output | DW | DSP0 input word |
| dsp0_ready | input | 1 | DSP0 input ready |
| dsp1_valid | output | 1 | DSP1 input valid |
| dsp1_data | output | DW | DSP1 input word |
| dsp1_ready | input | 1 | DSP1 input ready |

## Verification
The assertions assume three things about the inputs:
- Configuration is not rewritten for a buffer while one of its words is in flight on the loop path.
- Each configured buffer fits inside the RAM.
- Engines are started only after their programs have been written.

The stimulus configures buffers at disjoint base addresses. It loads each program fully before pulsing `rp_start`, and it reconfigures a buffer only while every engine that touches that buffer is idle or stalled on it. The bench drives egress ready low for long stretches, so the hold property and the priority order can be observed under back-pressure.

// File: rtl/rbe_pkg.sv
package rbe_pkg;
  typedef enum logic [1:0] {
    OP_HALT   = 2'd0,
    OP_READ   = 2'd1,
    OP_WAIT   = 2'd2,
    OP_SIGNAL = 2'd3
  } op_e;
  localparam int IW       = 16;
  localparam int NDEST    = 4;
  localparam int DEST_LOOP = 3;
endpackage

// File: rtl/rbe_ram.sv
module rbe_ram #(
  parameter int DW = 32,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rbe_arb.sv
module rbe_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // R9: lowest index wins
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end
endmodule

// File: rtl/rbe_proc.sv
module rbe_proc
  import rbe_pkg::*;
#(
  parameter int NP = 4,
  parameter int PD = 8,
  localparam int PW  = $clog2(PD),
  localparam int PIW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_we,
  input  logic [PW-1:0] prog_idx,
  input  logic [IW-1:0] prog_word,
  input  logic          start,
  input  logic          grant,
  input  logic [NP-1:0] token_in,
  output logic          want,
  output logic [1:0]    dest,
  output logic [1:0]    loop_buf,
  output logic [NP-1:0] token_set,
  output logic [NP-1:0] token_take,
  output logic          idle
);
  logic [IW-1:0] prog [PD];
  logic          running;
  logic [PW-1:0] pc;
  logic [9:0]    sent;
  logic [IW-1:0] instr;
  op_e           op;
  logic [9:0]    n_words;
  logic [PIW-1:0] peer;
  logic          advance;

  always_ff @(posedge clk) begin
    if (prog_we) prog[prog_idx] <= prog_word;
  end

  assign instr    = prog[pc];
  assign op       = op_e'(instr[15:14]);
  assign dest     = instr[13:12];
  assign loop_buf = instr[11:10];
  assign n_words  = instr[9:0];
  assign peer     = instr[PIW-1:0];
  assign idle     = !running;

  always_comb begin
    advance    = 1'b0;
    want       = 1'b0;
    token_set  = '0;
    token_take = '0;
    if (running) begin
      unique case (op)
        OP_READ: begin
          // R6 / R11: N = 0 finishes with no transfer
          if (sent == n_words) advance = 1'b1;
          else begin
            want = 1'b1;
            if (grant && (sent + 10'd1 == n_words)) advance = 1'b1;
          end
        end
        OP_WAIT: begin
          // R8
          if (token_in[peer]) begin
            token_take[peer] = 1'b1;
            advance = 1'b1;
          end
        end
        OP_SIGNAL: begin
          token_set[peer] = 1'b1;
          advance = 1'b1;
        end
        default: advance = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      pc      <= '0;
      sent    <= '0;
    end else if (start) begin
      running <= 1'b1;
      pc      <= '0;
      sent    <= '0;
    end else if (running) begin
      if (op == OP_HALT) running <= 1'b0;
      if (advance) begin
        pc   <= pc + PW'(1);
        sent <= '0;
      end else if (grant) begin
        sent <= sent + 10'd1;
      end
    end
  end
endmodule

// File: rtl/rbe_top.sv
module rbe_top
  import rbe_pkg::*;
#(
  parameter int NB = 4,
  parameter int DW = 32,
  parameter int AW = 11,
  parameter int PD = 8,
  localparam int BW = $clog2(NB),
  localparam int PW = $clog2(PD),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [BW-1:0] cfg_sel,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_size,
  input  logic          prog_we,
  input  logic [BW-1:0] prog_sel,
  input  logic [PW-1:0] prog_idx,
  input  logic [IW-1:0] prog_word,
  input  logic [NB-1:0] rp_start,
  output logic [NB-1:0] rp_idle,
  input  logic          in_valid,
  input  logic [BW-1:0] in_sel,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          net_valid,
  output logic [DW-1:0] net_data,
  input  logic          net_ready,
  output logic          dsp0_valid,
  output logic [DW-1:0] dsp0_data,
  input  logic          dsp0_ready,
  output logic          dsp1_valid,
  output logic [DW-1:0] dsp1_data,
  input  logic          dsp1_ready
);
  logic [NB-1:0][AW-1:0] base_q, wr_q, rd_q;
  logic [NB-1:0][CW-1:0] size_q, cnt_q;
  logic [NB-1:0][NB-1:0] tok_q;
  logic [NB-1:0][NB-1:0] tset, ttake;
  logic [NB-1:0]         want, req, gnt;
  logic [NB-1:0][1:0]    dest, lbuf;
  logic [BW-1:0]         rsel, wsel, lp_buf;
  logic                  any_gnt, st_vld, lp_wr, we;
  logic [1:0]            st_dest, st_lbuf;
  logic [NDEST-1:0]      o_vld, drain, dest_free;
  logic [NDEST-1:0][DW-1:0] o_dat;
  logic [DW-1:0]         ram_q;
  logic [NB-1:0]         wr_hit, rd_hit;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [CW-1:0] s);
    // R3: wrap at the end of the buffer
    return ({1'b0, p} + CW'(1) == s) ? '0 : p + AW'(1);
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_rp
      rbe_proc #(.NP(NB), .PD(PD)) u_proc (
        .clk(clk), .rst(rst),
        .prog_we(prog_we && prog_sel == BW'(gi)), .prog_idx(prog_idx), .prog_word(prog_word),
        .start(rp_start[gi]), .grant(gnt[gi]), .token_in(tok_q[gi]),
        .want(want[gi]), .dest(dest[gi]), .loop_buf(lbuf[gi]),
        .token_set(tset[gi]), .token_take(ttake[gi]), .idle(rp_idle[gi]));
      // R5: no request on an empty buffer
      assign req[gi] = want[gi] && (cnt_q[gi] != '0) && dest_free[dest[gi]];
    end
    for (gi = 0; gi < NDEST; gi++) begin : g_free
      assign dest_free[gi] = !o_vld[gi] && !(st_vld && st_dest == 2'(gi));
    end
  endgenerate

  rbe_arb #(.N(NB)) u_arb (.req(req), .gnt(gnt));

  always_comb begin
    rsel = '0;
    for (int i = 0; i < NB; i++) if (gnt[i]) rsel = BW'(i);
  end
  assign any_gnt = |gnt;

  // R7: loop path has priority on the write port
  assign lp_wr    = o_vld[DEST_LOOP] && (cnt_q[lp_buf] != size_q[lp_buf]);
  assign in_ready = !lp_wr && (cnt_q[in_sel] != size_q[in_sel]);
  assign we       = lp_wr || (in_valid && in_ready);
  assign wsel     = lp_wr ? lp_buf : in_sel;
  assign drain    = {lp_wr, dsp1_ready, dsp0_ready, net_ready};

  rbe_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(we), .waddr(base_q[wsel] + wr_q[wsel]),
    .wdata(lp_wr ? o_dat[DEST_LOOP] : in_data),
    .re(any_gnt), .raddr(base_q[rsel] + rd_q[rsel]), .rdata(ram_q));

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      wr_hit[b] = we && wsel == BW'(b);
      rd_hit[b] = any_gnt && rsel == BW'(b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0; size_q <= '0; wr_q <= '0; rd_q <= '0; cnt_q <= '0;
      tok_q  <= '0; st_vld <= 1'b0; st_dest <= '0; st_lbuf <= '0;
      o_vld  <= '0; lp_buf <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (cfg_we && cfg_sel == BW'(b)) begin
          // R2
          base_q[b] <= cfg_base; size_q[b] <= cfg_size;
          wr_q[b] <= '0; rd_q[b] <= '0; cnt_q[b] <= '0;
        end else begin
          if (wr_hit[b]) wr_q[b] <= step(wr_q[b], size_q[b]);
          if (rd_hit[b]) rd_q[b] <= step(rd_q[b], size_q[b]);
          cnt_q[b] <= cnt_q[b] + CW'(wr_hit[b]) - CW'(rd_hit[b]);
        end
        for (int p = 0; p < NB; p++) begin
          if (tset[p][b]) tok_q[b][p] <= 1'b1;
          else if (ttake[b][p]) tok_q[b][p] <= 1'b0;
        end
      end
      st_vld  <= any_gnt;
      st_dest <= dest[rsel];
      st_lbuf <= lbuf[rsel];
      for (int t = 0; t < NDEST; t++) begin
        if (st_vld && st_dest == 2'(t)) o_vld[t] <= 1'b1;
        else if (drain[t]) o_vld[t] <= 1'b0;
      end
      if (st_vld && st_dest == 2'(DEST_LOOP)) lp_buf <= BW'(st_lbuf);
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < NDEST; t++)
      if (st_vld && st_dest == 2'(t)) o_dat[t] <= ram_q;
  end

  assign net_valid  = o_vld[0];
  assign net_data   = o_dat[0];
  assign dsp0_valid = o_vld[1];
  assign dsp0_data  = o_dat[1];
  assign dsp1_valid = o_vld[2];
  assign dsp1_data  = o_dat[2];
endmodule

// File: rtl/rbe_chk.sv
module rbe_chk #(
  parameter int NB = 4,
  parameter int DW = 32,
  parameter int CW = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NB-1:0][CW-1:0] cnt,
  input logic [NB-1:0][CW-1:0] size,
  input logic [NB-1:0]         req,
  input logic [NB-1:0]         gnt,
  input logic                  net_valid,
  input logic                  net_ready,
  input logic [DW-1:0]         net_data,
  input logic                  dsp0_valid,
  input logic                  dsp0_ready,
  input logic [DW-1:0]         dsp0_data,
  input logic                  dsp1_valid,
  input logic                  dsp1_ready,
  input logic [DW-1:0]         dsp1_data
);
  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_buf
      // R4
      count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt[gi] <= size[gi]);
      // R5
      empty_stall_chk: assert property (@(posedge clk) disable iff (rst)
        gnt[gi] |-> cnt[gi] != '0);
      if (gi > 0) begin : g_pri
        // R9
        priority_chk: assert property (@(posedge clk) disable iff (rst)
          gnt[gi] |-> (req & ((NB'(1) << gi) - NB'(1))) == '0);
      end
    end
  endgenerate

  // R9
  single_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));

  // R10
  net_hold_chk: assert property (@(posedge clk) disable iff (rst)
    net_valid && !net_ready |=> net_valid && $stable(net_data));
  // R10
  dsp0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dsp0_valid && !dsp0_ready |=> dsp0_valid && $stable(dsp0_data));
  // R10
  dsp1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dsp1_valid && !dsp1_ready |=> dsp1_valid && $stable(dsp1_data));
endmodule

bind rbe_top rbe_chk #(.NB(NB), .DW(DW), .CW(CW)) i_chk (
  .clk(clk), .rst(rst), .cnt(cnt_q), .size(size_q), .req(req), .gnt(gnt),
  .net_valid(net_valid), .net_ready(net_ready), .net_data(net_data),
  .dsp0_valid(dsp0_valid), .dsp0_ready(dsp0_ready), .dsp0_data(dsp0_data),
  .dsp1_valid(dsp1_valid), .dsp1_ready(dsp1_ready), .dsp1_data(dsp1_data));

// File: tb/test_rbe_top.sv
module test_rbe_top;
  localparam int NB = 4, DW = 32, AW = 11, PD = 8;
  localparam logic [1:0] HALT = 2'd0, READ = 2'd1, WAITP = 2'd2, SIG = 2'd3;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, prog_we = 0, in_valid = 0;
  logic [1:0] cfg_sel = 0, prog_sel = 0, in_sel = 0;
  logic [AW-1:0] cfg_base = 0;
  logic [AW:0] cfg_size = 0;
  logic [2:0] prog_idx = 0;
  logic [15:0] prog_word = 0;
  logic [NB-1:0] rp_start = 0, rp_idle;
  logic [DW-1:0] in_data = 0, net_data, dsp0_data, dsp1_data;
  logic in_ready, net_valid, dsp0_valid, dsp1_valid;
  logic net_ready = 0, dsp0_ready = 0, dsp1_ready = 0;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rbe_top #(.NB(NB), .DW(DW), .AW(AW), .PD(PD)) i_rbe_top (.*);

  // table: {destination, word}
  localparam logic [5:0][33:0] VEC = {
    {2'd0, 32'hA000_0001}, {2'd1, 32'hA000_0002}, {2'd2, 32'hA000_0003},
    {2'd2, 32'h5555_AAAA}, {2'd0, 32'hFFFF_FFFF}, {2'd1, 32'h0000_0000}};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [1:0] op, input logic [1:0] d,
                                     input logic [1:0] lb, input logic [9:0] n);
    return {op, d, lb, n};
  endfunction

  task automatic cfg(input int b, input int base, input int size);
    @(negedge clk); cfg_we = 1; cfg_sel = 2'(b); cfg_base = AW'(base); cfg_size = (AW+1)'(size);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic prog(input int p, input int idx, input logic [15:0] w);
    @(negedge clk); prog_we = 1; prog_sel = 2'(p); prog_idx = 3'(idx); prog_word = w;
    @(negedge clk); prog_we = 0;
  endtask

  task automatic start(input logic [3:0] m);
    @(negedge clk); rp_start = m;
    @(negedge clk); rp_start = 0;
  endtask

  task automatic push(input int b, input logic [31:0] d);
    int k = 0;
    @(negedge clk); in_valid = 1; in_sel = 2'(b); in_data = d;
    #1;
    while (!in_ready && k < 200) begin @(negedge clk); #1; k++; end
    if (k >= 200) chk(0, "R4 push timeout", 0, d);
    @(negedge clk); in_valid = 0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic vld_of(input int t);
    return t == 0 ? net_valid : t == 1 ? dsp0_valid : dsp1_valid;
  endfunction
  function automatic logic [31:0] dat_of(input int t);
    return t == 0 ? net_data : t == 1 ? dsp0_data : dsp1_data;
  endfunction

  task automatic set_rdy(input int t, input logic v);
    if (t == 0) net_ready = v; else if (t == 1) dsp0_ready = v; else dsp1_ready = v;
  endtask

  task automatic pop(input int t, input logic [31:0] exp, input string tag);
    bit got = 0;
    for (int k = 0; k < 200 && !got; k++) begin
      @(negedge clk);
      if (vld_of(t)) begin
        got = 1;
        chk(dat_of(t) == exp, tag, dat_of(t), exp);
        set_rdy(t, 1);
        @(negedge clk);
        set_rdy(t, 0);
      end
    end
    if (!got) chk(0, {tag, " no output"}, 0, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitc(3);
    rst = 0;
    @(negedge clk); #1;
    // R1 reset state; R2 unconfigured buffer (size 0) refuses
    chk(!net_valid && !dsp0_valid && !dsp1_valid, "R1 outputs idle", {29'b0, net_valid, dsp0_valid, dsp1_valid}, 0);
    chk(rp_idle == 4'hF, "R1 engines idle", 32'(rp_idle), 32'hF);
    chk(!in_ready, "R2 size0 refuses", 32'(in_ready), 0);

    cfg(0, 0, 4); cfg(1, 100, 4); cfg(2, 200, 4); cfg(3, 300, 2);

    // R6 table walk: each word routed to one destination only
    for (int i = 0; i < 6; i++) begin
      push(0, VEC[i][31:0]);
      prog(0, 0, mk(READ, VEC[i][33:32], 0, 1));
      prog(0, 1, mk(HALT, 0, 0, 0));
      start(4'b0001);
      pop(int'(VEC[i][33:32]), VEC[i][31:0], "R6 routed word");
      waitc(2);
      chk(!net_valid && !dsp0_valid && !dsp1_valid, "R6 no stray output", 32'({net_valid, dsp0_valid, dsp1_valid}), 0);
    end

    // R4 full buffer, R3 order and wrap
    for (int i = 0; i < 4; i++) push(1, 32'h11 + i);
    @(negedge clk); in_sel = 1; #1;
    chk(!in_ready, "R4 full refuses", 32'(in_ready), 0);
    prog(1, 0, mk(READ, 0, 0, 4)); prog(1, 1, mk(HALT, 0, 0, 0));
    start(4'b0010);
    for (int i = 0; i < 4; i++) pop(0, 32'h11 + i, "R3 order");
    for (int i = 0; i < 3; i++) push(1, 32'h21 + i);
    prog(1, 0, mk(READ, 0, 0, 3));
    start(4'b0010);
    for (int i = 0; i < 3; i++) pop(0, 32'h21 + i, "R3 wrap order");

    // R5 empty stall
    prog(2, 0, mk(READ, 2, 0, 2)); prog(2, 1, mk(HALT, 0, 0, 0));
    start(4'b0100);
    waitc(8);
    chk(!dsp1_valid && !rp_idle[2], "R5 stalled empty", 32'({dsp1_valid, rp_idle[2]}), 0);
    push(2, 32'h31);
    pop(2, 32'h31, "R5 resume");
    waitc(5);
    chk(!dsp1_valid && !rp_idle[2], "R5 stalled again", 32'({dsp1_valid, rp_idle[2]}), 0);
    push(2, 32'h32);
    pop(2, 32'h32, "R5 second word");
    waitc(3);
    chk(rp_idle[2], "R11 idle after halt", 32'(rp_idle[2]), 1);

    // R8 token wait
    push(3, 32'h41);
    prog(3, 0, mk(WAITP, 0, 0, 0)); prog(3, 1, mk(READ, 0, 0, 1)); prog(3, 2, mk(HALT, 0, 0, 0));
    start(4'b1000);
    waitc(10);
    chk(!net_valid && !rp_idle[3], "R8 waits for token", 32'({net_valid, rp_idle[3]}), 0);
    prog(0, 0, mk(SIG, 0, 0, 3)); prog(0, 1, mk(HALT, 0, 0, 0));
    start(4'b0001);
    pop(0, 32'h41, "R8 released");

    // R7 loop path buf0 -> buf2 -> network
    push(0, 32'h51); push(0, 32'h52);
    prog(0, 0, mk(READ, 3, 2, 2)); prog(0, 1, mk(HALT, 0, 0, 0));
    prog(2, 0, mk(READ, 0, 0, 2)); prog(2, 1, mk(HALT, 0, 0, 0));
    start(4'b0101);
    pop(0, 32'h51, "R7 loop word 1");
    pop(0, 32'h52, "R7 loop word 2");

    // R9 priority and R10 hold
    push(0, 32'h61); push(1, 32'h62);
    prog(0, 0, mk(READ, 0, 0, 1)); prog(0, 1, mk(HALT, 0, 0, 0));
    prog(1, 0, mk(READ, 0, 0, 1)); prog(1, 1, mk(HALT, 0, 0, 0));
    start(4'b0011);
    waitc(10);
    chk(net_valid && net_data == 32'h61, "R10 held under backpressure", net_data, 32'h61);
    pop(0, 32'h61, "R9 engine0 first");
    pop(0, 32'h62, "R9 engine1 second");

    // R11 READ with N = 0
    prog(1, 0, mk(READ, 0, 0, 0)); prog(1, 1, mk(HALT, 0, 0, 0));
    start(4'b0010);
    waitc(5);
    chk(rp_idle[1] && !net_valid, "R11 zero-length read", 32'({rp_idle[1], net_valid}), 32'h2);

    // R2 reconfiguration empties; size 0 refuses
    push(0, 32'h71); push(0, 32'h72);
    cfg(0, 0, 4);
    prog(0, 0, mk(READ, 1, 0, 1)); prog(0, 1, mk(HALT, 0, 0, 0));
    start(4'b0001);
    waitc(8);
    chk(!dsp0_valid, "R2 reconfig empties", 32'(dsp0_valid), 0);
    push(0, 32'h73);
    pop(1, 32'h73, "R2 new word after reconfig");
    cfg(3, 300, 0);
    @(negedge clk); in_sel = 3; #1;
    chk(!in_ready, "R2 size0 refuses", 32'(in_ready), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule